// File: doc/BRIEF.md
# Reset-time boot mode controller

The block captures four mode strap inputs for as long as the active-low reset is held, then decodes them into a boot method and a memory configuration. After reset is released the strap pins are free for other use, and later activity on them does not change the captured mode.

There are three boot methods. In the byte-copy boot the block reads a fixed number of bytes from byte memory. It packs each group of three bytes into one 24-bit program word and writes the words into internal program memory at addresses 0 upward. In the host boot the block only watches the host's writes to program memory, and it releases the core when the host writes program address 0. In the no-boot mode the core is released at once and starts from external address 0. After either boot sequence, the core starts at internal address 0.

The decoded memory mode is an output of the block. In host mode the block also controls the acknowledge pin driver, as push-pull or as open drain. If reset is asserted during a boot, the boot is aborted and starts again from the beginning.

Top module: `boot_ctrl`

## Requirements
- R1: The straps mode_i (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) are captured on clock edges while rst_ni is low. Changes on mode_i after reset release do not alter core_run_o, host_mode_o, start_ext_o or the acknowledge outputs.
- R2: With C=0, B=0, A=0 (D ignored), the block reads byte addresses 0 to 95 in ascending order, one read per cycle. Read data is valid on bm_data_i the cycle after bm_rd_o. Each group of three bytes is written as one word, so program address i receives {byte 3i, byte 3i+1, byte 3i+2}, most significant byte first. The 32 writes go to addresses 0 to 31 in order.
- R3: In a byte-copy boot, core_run_o stays low until the last word is written and rises on the next clock edge. The first rising clock edge after reset release starts the copy, so core_run_o is high after 98 rising edges. start_ext_o is 0 (the core starts at internal address 0).
- R4: With C=0, B=0, A=1, no boot occurs. core_run_o is high after the first rising edge following reset release, start_ext_o is 1, and no program-memory write is issued.
- R5: With C=1, B=0, A=1, the block waits for the host. A host write to a nonzero address leaves core_run_o low. A host write to address 0 makes core_run_o high after that clock edge. The block itself issues no program-memory writes.
- R6: host_mode_o is 1 for C=1, B=0 and 0 for every other strap value. C=1, B=0, A=0 selects the byte-copy boot in host mode.
- R7: The acknowledge outputs depend on the mode. In host mode with D=0, ack_oe_o=1 and ack_o=ack_i. In host mode with D=1, ack_o=0 and ack_oe_o=!ack_i (drive low only). In full-memory mode, ack_oe_o=0 and ack_o=0.
- R8: Any strap value with B=1 behaves as the no-boot, full-memory mode.
- R9: Asserting reset during a byte copy aborts it and captures the straps again. After the new release, the boot follows the newly captured mode, and a byte copy restarts from word 0 and byte address 0.
- R10: While rst_ni is low, core_run_o, boot_done_o, bm_rd_o and pm_we_o are 0. boot_done_o equals core_run_o at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; straps captured while low |
| mode_i | input | 4 | Strap inputs {D, C, B, A} |
| bm_rd_o | output | 1 | Byte-memory read strobe |
| bm_addr_o | output | BM_AW | Byte-memory read address |
| bm_data_i | input | 8 | Byte read data, valid one cycle after the strobe |
| pm_we_o | output | 1 | Program-memory write enable |
| pm_addr_o | output | PM_AW | Program-memory write address |
| pm_data_o | output | 24 | Program-memory write data |
| host_we_i | input | 1 | Snooped host write to program memory |
| host_addr_i | input | PM_AW | Address of the snooped host write |
| ack_i | input | 1 | Requested acknowledge level |
| ack_o | output | 1 | Acknowledge pin output value |
| ack_oe_o | output | 1 | Acknowledge pin output enable |
| core_run_o | output | 1 | Core may execute |
| boot_done_o | output | 1 | Boot finished, high while the core runs |
| start_ext_o | output | 1 | 1: start at external address 0; 0: internal address 0 |
| host_mode_o | output | 1 | 1: host memory mode; 0: full-memory mode |

## Verification
The byte-copy boot runs on a byte image built from an address hash, so misordered bytes, wrong word addresses or a dropped word all show up in the written image. The release is timed to the exact edge to expose an early or a late start. The host boot is given a nonzero-address write before the address-0 write, which separates a release on address 0 from a release on any write. Each strap class is run once, including a reserved value, with D toggled in host mode so the push-pull and open-drain drivers can be told apart. Two mid-copy resets, one re-captured as byte copy and one as no-boot, separate a true restart from resuming the old copy or keeping stale straps.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {BOOT_NONE, BOOT_BYTE, BOOT_HOST} boot_e;
  typedef enum logic [1:0] {ST_START, ST_COPY, ST_HOST, ST_RUN} state_e;

  typedef struct packed {
    boot_e method;
    logic  host;
    logic  open_drain;
  } cfg_t;

  // straps {D,C,B,A}; B=1 is reserved and falls back to no-boot
  function automatic cfg_t decode_straps(input logic [3:0] m);
    cfg_t c;
    c.host       = 1'b0;
    c.open_drain = 1'b0;
    c.method     = BOOT_NONE;
    if (!m[1]) begin
      if (m[2]) begin
        c.host       = 1'b1;
        c.open_drain = m[3];
        c.method     = m[0] ? BOOT_HOST : BOOT_BYTE;
      end else begin
        c.method     = m[0] ? BOOT_NONE : BOOT_BYTE;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  output logic [3:0] mode_o,
  output cfg_t       cfg_o
);
  logic [3:0] mode_q;

  // sampled only while reset is held; clock runs during reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_i;
  end

  assign mode_o = mode_q;
  assign cfg_o  = decode_straps(mode_q);
endmodule

// File: rtl/boot_byte_copy.sv
module boot_byte_copy #(
  parameter int NWORDS    = 32,
  parameter int BYTES_PER = 3,
  parameter int BM_AW     = 16,
  parameter int PM_AW     = 14,
  localparam int WORD_W   = 8 * BYTES_PER,
  localparam int TOTAL    = NWORDS * BYTES_PER,
  localparam int CW       = $clog2(TOTAL + 1),
  localparam int WW       = $clog2(NWORDS + 1),
  localparam int LW       = $clog2(BYTES_PER)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              bm_rd_o,
  output logic [BM_AW-1:0]  bm_addr_o,
  input  logic [7:0]        bm_data_i,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_data_o,
  output logic              last_o
);
  logic [CW-1:0]       rd_cnt_q;
  logic                rd_q;
  logic [LW-1:0]       lane_q;
  logic [WW-1:0]       word_q;
  logic [WORD_W-9:0]   acc_q;
  logic                lane_end;

  assign bm_rd_o   = en_i && (rd_cnt_q < CW'(TOTAL));
  assign bm_addr_o = BM_AW'(rd_cnt_q);
  assign lane_end  = (lane_q == LW'(BYTES_PER - 1));
  assign pm_we_o   = en_i && rd_q && lane_end;
  assign pm_addr_o = PM_AW'(word_q);
  assign pm_data_o = {acc_q, bm_data_i};
  assign last_o    = pm_we_o && (word_q == WW'(NWORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      rd_q     <= 1'b0;
      lane_q   <= '0;
      word_q   <= '0;
      acc_q    <= '0;
    end else if (!en_i) begin
      rd_cnt_q <= '0;
      rd_q     <= 1'b0;
      lane_q   <= '0;
      word_q   <= '0;
    end else begin
      rd_q <= bm_rd_o;
      if (bm_rd_o) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (rd_q) begin
        acc_q <= {acc_q[WORD_W-17:0], bm_data_i};
        if (lane_end) begin
          lane_q <= '0;
          word_q <= word_q + 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/boot_ack_drv.sv
module boot_ack_drv (
  input  logic host_i,
  input  logic open_drain_i,
  input  logic ack_i,
  output logic ack_o,
  output logic ack_oe_o
);
  always_comb begin
    ack_o    = 1'b0;
    ack_oe_o = 1'b0;
    if (host_i) begin
      if (open_drain_i) begin
        ack_oe_o = !ack_i;
      end else begin
        ack_o    = ack_i;
        ack_oe_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int NWORDS    = 32,
  parameter int BYTES_PER = 3,
  parameter int BM_AW     = 16,
  parameter int PM_AW     = 14,
  localparam int WORD_W   = 8 * BYTES_PER
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  output logic              bm_rd_o,
  output logic [BM_AW-1:0]  bm_addr_o,
  input  logic [7:0]        bm_data_i,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_data_o,
  input  logic              host_we_i,
  input  logic [PM_AW-1:0]  host_addr_i,
  input  logic              ack_i,
  output logic              ack_o,
  output logic              ack_oe_o,
  output logic              core_run_o,
  output logic              boot_done_o,
  output logic              start_ext_o,
  output logic              host_mode_o
);
  cfg_t       cfg;
  logic [3:0] mode_q;
  state_e     state_q, state_d;
  logic       copy_last;

  boot_strap_latch i_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .mode_o (mode_q),
    .cfg_o  (cfg)
  );

  boot_byte_copy #(
    .NWORDS   (NWORDS),
    .BYTES_PER(BYTES_PER),
    .BM_AW    (BM_AW),
    .PM_AW    (PM_AW)
  ) i_copy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_COPY),
    .bm_rd_o  (bm_rd_o),
    .bm_addr_o(bm_addr_o),
    .bm_data_i(bm_data_i),
    .pm_we_o  (pm_we_o),
    .pm_addr_o(pm_addr_o),
    .pm_data_o(pm_data_o),
    .last_o   (copy_last)
  );

  boot_ack_drv i_ack (
    .host_i      (cfg.host),
    .open_drain_i(cfg.open_drain),
    .ack_i       (ack_i),
    .ack_o       (ack_o),
    .ack_oe_o    (ack_oe_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: begin
        unique case (cfg.method)
          BOOT_BYTE: state_d = ST_COPY;
          BOOT_HOST: state_d = ST_HOST;
          default:   state_d = ST_RUN;
        endcase
      end
      ST_COPY: if (copy_last) state_d = ST_RUN;
      ST_HOST: if (host_we_i && host_addr_i == '0) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_START;
    else         state_q <= state_d;
  end

  assign core_run_o  = (state_q == ST_RUN);
  assign boot_done_o = core_run_o;
  assign start_ext_o = (cfg.method == BOOT_NONE);
  assign host_mode_o = cfg.host;
endmodule

// File: rtl/boot_ctrl_chk.sv
module boot_ctrl_chk
  import boot_pkg::*;
#(
  parameter int BM_AW = 16,
  parameter int PM_AW = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       mode_q,
  input state_e           state_q,
  input logic             bm_rd_o,
  input logic [BM_AW-1:0] bm_addr_o,
  input logic             pm_we_o,
  input logic             host_we_i,
  input logic [PM_AW-1:0] host_addr_i,
  input logic             ack_o,
  input logic             ack_oe_o,
  input logic             core_run_o,
  input logic             boot_done_o,
  input logic             host_mode_o
);
  p_strap_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q));

  p_byte_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_rd_o && $past(bm_rd_o) |-> bm_addr_o == $past(bm_addr_o) + 1'b1);

  p_run_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_run_o |=> core_run_o);

  p_no_write_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_run_o |-> !pm_we_o && !bm_rd_o);

  p_host_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOST && host_we_i && host_addr_i == '0 |=> core_run_o);

  p_host_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOST |-> !pm_we_o);

  p_ack_host_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o |-> host_mode_o);

  p_ack_high_driven_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_oe_o);

  p_reset_idle_r10: assert property (@(posedge clk_i)
    !rst_ni |-> !core_run_o && !pm_we_o && !bm_rd_o);

  p_done_run_r10: assert property (@(posedge clk_i)
    boot_done_o == core_run_o);
endmodule

bind boot_ctrl boot_ctrl_chk #(.BM_AW(BM_AW), .PM_AW(PM_AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q     (mode_q),
  .state_q    (state_q),
  .bm_rd_o    (bm_rd_o),
  .bm_addr_o  (bm_addr_o),
  .pm_we_o    (pm_we_o),
  .host_we_i  (host_we_i),
  .host_addr_i(host_addr_i),
  .ack_o      (ack_o),
  .ack_oe_o   (ack_oe_o),
  .core_run_o (core_run_o),
  .boot_done_o(boot_done_o),
  .host_mode_o(host_mode_o)
);

// File: tb/test_boot_ctrl.sv
`timescale 1ns/1ps
module test_boot_ctrl;
  localparam int BM_AW = 16;
  localparam int PM_AW = 14;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0]       mode_i = 4'b0000;
  logic             bm_rd_o;
  logic [BM_AW-1:0] bm_addr_o;
  logic [7:0]       bm_data = 8'h00;
  logic             pm_we_o;
  logic [PM_AW-1:0] pm_addr_o;
  logic [23:0]      pm_data_o;
  logic             host_we = 1'b0;
  logic [PM_AW-1:0] host_addr = '0;
  logic             ack_req = 1'b0;
  logic             ack_o, ack_oe_o, core_run_o, boot_done_o, start_ext_o, host_mode_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  boot_ctrl i_boot_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .bm_rd_o(bm_rd_o), .bm_addr_o(bm_addr_o), .bm_data_i(bm_data),
    .pm_we_o(pm_we_o), .pm_addr_o(pm_addr_o), .pm_data_o(pm_data_o),
    .host_we_i(host_we), .host_addr_i(host_addr), .ack_i(ack_req),
    .ack_o(ack_o), .ack_oe_o(ack_oe_o), .core_run_o(core_run_o),
    .boot_done_o(boot_done_o), .start_ext_o(start_ext_o), .host_mode_o(host_mode_o)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // synchronous byte memory: data one cycle after the read strobe
  always @(posedge clk) if (bm_rd_o) bm_data <= img(int'(bm_addr_o));

  // program-memory write monitor
  logic [23:0] pm_model [32];
  int          wr_cnt = 0;
  logic        order_bad = 1'b0;
  logic        run_bad = 1'b0;
  logic        mon_clr = 1'b0;
  always @(posedge clk) begin
    if (mon_clr) begin
      wr_cnt    <= 0;
      order_bad <= 1'b0;
      run_bad   <= 1'b0;
    end else if (pm_we_o) begin
      pm_model[pm_addr_o[4:0]] <= pm_data_o;
      if (int'(pm_addr_o) != wr_cnt) order_bad <= 1'b1;
      if (core_run_o) run_bad <= 1'b1;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk);
    rst_ni  = 1'b0;
    mode_i  = m;
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    mon_clr = 1'b0;
    rst_ni  = 1'b1;
  endtask

  task automatic check_image(input string req);
    int bad = 0;
    for (int i = 0; i < 32; i++)
      if (pm_model[i] != {img(3*i), img(3*i+1), img(3*i+2)}) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(!core_run_o && !boot_done_o && !bm_rd_o && !pm_we_o, "R10",
        {core_run_o, boot_done_o, bm_rd_o, pm_we_o}, 0);
  endtask

  task automatic t_byte_full;
    do_reset(4'b1000);             // D is don't-care here
    repeat (97) @(negedge clk);
    chk(!core_run_o, "R3 early", core_run_o, 0);
    @(negedge clk);
    chk(core_run_o && boot_done_o, "R3 release", {core_run_o, boot_done_o}, 2'b11);
    chk(!start_ext_o, "R3 start", start_ext_o, 0);
    chk(wr_cnt == 32 && !order_bad && !run_bad, "R2 writes", wr_cnt, 32);
    check_image("R2 image");
    chk(!host_mode_o && !ack_oe_o, "R6 full", {host_mode_o, ack_oe_o}, 0);
    mode_i = 4'b0101;
    repeat (3) @(negedge clk);
    chk(core_run_o && !host_mode_o && !start_ext_o && !ack_oe_o, "R1 run",
        {core_run_o, host_mode_o, start_ext_o, ack_oe_o}, 4'b1000);
  endtask

  task automatic t_byte_host_pp;
    do_reset(4'b0100);
    @(negedge clk);
    chk(host_mode_o, "R6 byte host", host_mode_o, 1);
    ack_req = 1'b1;
    #1;
    chk(ack_oe_o && ack_o, "R7 pp high", {ack_oe_o, ack_o}, 2'b11);
    ack_req = 1'b0;
    #1;
    chk(ack_oe_o && !ack_o, "R7 pp low", {ack_oe_o, ack_o}, 2'b10);
    repeat (97) @(negedge clk);
    chk(core_run_o && wr_cnt == 32 && !order_bad, "R6 byte boot", wr_cnt, 32);
    check_image("R6 image");
  endtask

  task automatic t_host_od;
    do_reset(4'b1101);
    repeat (2) @(negedge clk);
    chk(!core_run_o && host_mode_o, "R5 wait", {core_run_o, host_mode_o}, 2'b01);
    ack_req = 1'b1;
    #1;
    chk(!ack_oe_o && !ack_o, "R7 od release", {ack_oe_o, ack_o}, 0);
    ack_req = 1'b0;
    #1;
    chk(ack_oe_o && !ack_o, "R7 od low", {ack_oe_o, ack_o}, 2'b10);
    mode_i = 4'b0001;              // strap change while waiting
    host_we = 1'b1;
    host_addr = 14'd5;
    @(negedge clk);
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!core_run_o && host_mode_o && !start_ext_o, "R5 R1 nonzero",
        {core_run_o, host_mode_o, start_ext_o}, 3'b010);
    host_we = 1'b1;
    host_addr = '0;
    @(negedge clk);
    host_we = 1'b0;
    chk(core_run_o && !start_ext_o, "R5 release", {core_run_o, start_ext_o}, 2'b10);
    chk(wr_cnt == 0, "R5 no writes", wr_cnt, 0);
  endtask

  task automatic t_noboot;
    do_reset(4'b0001);
    chk(!core_run_o, "R4 before edge", core_run_o, 0);
    @(negedge clk);
    chk(core_run_o && start_ext_o && !host_mode_o, "R4 run",
        {core_run_o, start_ext_o, host_mode_o}, 3'b110);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0 && !bm_rd_o, "R4 no copy", wr_cnt, 0);
  endtask

  task automatic t_reserved;
    do_reset(4'b0110);
    @(negedge clk);
    chk(core_run_o && start_ext_o && !host_mode_o && !ack_oe_o, "R8 reserved",
        {core_run_o, start_ext_o, host_mode_o, ack_oe_o}, 4'b1100);
  endtask

  task automatic t_abort;
    do_reset(4'b0000);
    repeat (40) @(negedge clk);
    chk(wr_cnt > 0 && !core_run_o, "R9 mid copy", wr_cnt, 13);
    do_reset(4'b0000);
    repeat (98) @(negedge clk);
    chk(core_run_o && wr_cnt == 32 && !order_bad, "R9 restart", wr_cnt, 32);
    check_image("R9 image");
    do_reset(4'b0000);
    repeat (30) @(negedge clk);
    do_reset(4'b0001);
    @(negedge clk);
    chk(core_run_o && start_ext_o && wr_cnt == 0, "R9 relatch",
        {core_run_o, start_ext_o}, 2'b11);
  endtask

  initial begin
    t_reset_state();
    t_byte_full();
    t_byte_host_pp();
    t_host_od();
    t_noboot();
    t_reserved();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule